// File: doc/BRIEF.md
# Cascadable Reload-Compare Down Timer

The block holds two 8-bit down counters that count on falling edges of a slow, asynchronous timer clock. Each counter has a reload value, a compare value, a run control and a preset action, and its current count can be read at any time. When the new count equals the compare value, the counter emits a one-cycle compare pulse and toggles its clock output. When a falling edge finds the counter at zero, it emits a one-cycle underflow pulse, and the counter takes its reload value on the next rising edge of the timer clock. Neither event stops the counting.

A mode input fuses the two counters into one 16-bit counter. The low counter is the least significant byte. Only the low counter's run bit governs the pair, and all events are reported on the low counter's outputs. The timer clock is resampled through two flops in the system clock domain. Its edges are found from that sample, so the timer clock must stay in each level for at least two system clock cycles.

Top module: `reload_cmp_timer`

## Requirements
- R1: After reset every register, both counts and both timer outputs read zero, and no event pulse is present.
- R2: The register at address {t,2'b01} holds timer t's reload value and {t,2'b10} holds its compare value. Both are read and written through the same address. In 16-bit mode the compare value is {compare of timer 1, compare of timer 0}.
- R3: Address {t,2'b11} reads timer t's count. A running timer decrements by one for each falling edge of the timer clock.
- R4: Address {t,2'b00} is control: bit 0 is run and reads back. Clearing run freezes the count and the timer output, and setting it again resumes from the held count.
- R5: When a decrement produces a count equal to the compare value, a one-cycle compare pulse is issued and that timer's output toggles. The output changes at no other time.
- R6: A falling edge at count zero issues a one-cycle underflow pulse and leaves the count at zero. The next rising edge of the timer clock loads the reload value, and counting continues down from it.
- R7: Writing control with bit 1 set loads the reload value into that timer's count.
- R8: In 8-bit mode each timer counts under its own run bit only.
- R9: In 16-bit mode the high counter decrements only when the low counter steps from 00h to FFh. Underflow happens at 0000h and reloads both halves. Events appear only on index 0, and index 1's pulses stay low and its output holds.
- R10: In 16-bit mode writes to timer 1's run bit are ignored, and the bit reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tclk | input | 1 | Asynchronous timer input clock |
| mode16 | input | 1 | 1 chains both counters into one 16-bit timer |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address {timer, select} |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| irq_cmp | output | 2 | Compare-match pulses, one per timer |
| irq_unf | output | 2 | Underflow pulses, one per timer |
| tout | output | 2 | Timer outputs toggled by compare match |

## Verification
The bench checks the count at the underflow edge, which must still read zero, and again after the following rising edge, which must show the reload value. A design that reloaded at once, or only on the next falling edge, would show a wrong value at one of these two points. In 16-bit mode it runs the pair through the low byte's wrap from 00h to FFh and on down to 0000h. A design that borrowed wrongly would miss the 16-bit compare, and one that routed events to the wrong index would light index 1. It also stops and restarts timers and writes the high run bit in 16-bit mode. A design that lost the held count, moved the output while stopped, or let that write take effect would then read back wrong values.

// File: rtl/timer_pkg.sv
// Shared constants and register selectors for the reload-compare timer.
package timer_pkg;
    localparam int NUM_HALVES = 2;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_CMP    = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_e;

    localparam int CTRL_RUN_BIT    = 0;
    localparam int CTRL_PRESET_BIT = 1;
endpackage

// File: rtl/tclk_edge.sv
// Resamples the asynchronous timer clock through two flops and flags its
// falling and rising edges as one-cycle strobes in the system clock domain.
// Assumes the timer clock holds each level for at least two system cycles.
module tclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tclk,
    output logic fall,
    output logic rise
);
    logic s1, s2, prev;

    // Two-flop synchroniser followed by a history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= tclk;
            s2   <= s1;
            prev <= s2;
        end
    end

    // Edge strobes from the synchronised level and its history.
    assign fall = prev & ~s2;
    assign rise = ~prev & s2;

    a_r3_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
    a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/timer_regs.sv
// Register file: reload, compare and run bits per timer, preset strobes,
// and the read multiplexer. Assumes the counts come back from the core.
module timer_regs #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode16,
    input  logic                wr_en,
    input  logic [2:0]          addr,
    input  logic [W-1:0]        wdata,
    input  logic [1:0][W-1:0]   cnt,
    output logic [W-1:0]        rdata,
    output logic [1:0]          run_eff,
    output logic [1:0]          preset,
    output logic [1:0][W-1:0]   rld,
    output logic [1:0][W-1:0]   cmp
);
    import timer_pkg::*;

    logic [1:0] run_q;
    reg_sel_e   sel;
    logic       tsel;

    assign sel  = reg_sel_e'(addr[1:0]);
    assign tsel = addr[2];

    // Register writes; high run bit is locked while the pair is chained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            rld   <= '0;
            cmp   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    if (!(mode16 && tsel))
                        run_q[tsel] <= wdata[CTRL_RUN_BIT];
                end
                SEL_RELOAD: rld[tsel] <= wdata;
                SEL_CMP:    cmp[tsel] <= wdata;
                default: ;
            endcase
        end
    end

    // Preset strobes act in the write cycle.
    always_comb begin
        preset = '0;
        if (wr_en && sel == SEL_CTRL)
            preset[tsel] = wdata[CTRL_PRESET_BIT];
    end

    // In 16-bit mode both halves follow the low timer's run bit.
    assign run_eff[0] = run_q[0];
    assign run_eff[1] = mode16 ? run_q[0] : run_q[1];

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL:   rdata[CTRL_RUN_BIT] = run_q[tsel];
            SEL_RELOAD: rdata = rld[tsel];
            SEL_CMP:    rdata = cmp[tsel];
            default:    rdata = cnt[tsel];
        endcase
    end

    a_r10_hi_run_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode16 && addr == 3'b100) |=> run_q[1] == $past(run_q[1]));
endmodule

// File: rtl/timer_core.sv
// Counting core for both halves: decrement on falling timer-clock edges,
// compare match with output toggle, underflow with reload on the following
// rising edge, preset, and 16-bit chaining. Event pulses last one cycle.
module timer_core #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode16,
    input  logic                fall,
    input  logic                rise,
    input  logic [1:0]          run_eff,
    input  logic [1:0]          preset,
    input  logic [1:0][W-1:0]   rld,
    input  logic [1:0][W-1:0]   cmp,
    output logic [1:0][W-1:0]   cnt,
    output logic [1:0]          irq_cmp,
    output logic [1:0]          irq_unf,
    output logic [1:0]          tout
);
    localparam int FW = 2 * W;

    logic [1:0]    pend;
    logic [FW-1:0] full, full_m1, cmp_full;

    // 16-bit views of the pair.
    assign full     = cnt;
    assign full_m1  = full - FW'(1);
    assign cmp_full = cmp;

    // Counter, pending-reload, output and event-pulse state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pend    <= '0;
            tout    <= '0;
            irq_cmp <= '0;
            irq_unf <= '0;
        end else begin
            irq_cmp <= '0;
            irq_unf <= '0;
            if (fall) begin
                if (mode16) begin
                    if (run_eff[0]) begin
                        if (full == '0) begin
                            pend       <= 2'b11;
                            irq_unf[0] <= 1'b1;
                        end else begin
                            cnt <= full_m1;
                            if (full_m1 == cmp_full) begin
                                tout[0]    <= ~tout[0];
                                irq_cmp[0] <= 1'b1;
                            end
                        end
                    end
                end else begin
                    for (int i = 0; i < 2; i++) begin
                        if (run_eff[i]) begin
                            if (cnt[i] == '0) begin
                                pend[i]    <= 1'b1;
                                irq_unf[i] <= 1'b1;
                            end else begin
                                cnt[i] <= cnt[i] - W'(1);
                                if (cnt[i] - W'(1) == cmp[i]) begin
                                    tout[i]    <= ~tout[i];
                                    irq_cmp[i] <= 1'b1;
                                end
                            end
                        end
                    end
                end
            end
            if (rise) begin
                for (int i = 0; i < 2; i++) begin
                    if (pend[i]) begin
                        cnt[i]  <= rld[i];
                        pend[i] <= 1'b0;
                    end
                end
            end
            for (int i = 0; i < 2; i++) begin
                if (preset[i]) begin
                    cnt[i]  <= rld[i];
                    pend[i] <= 1'b0;
                end
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_chk
            a_r5_cmp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                irq_cmp[g] |=> !irq_cmp[g]);
            a_r6_unf_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                irq_unf[g] |=> !irq_unf[g]);
            a_r5_tout_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
                !irq_cmp[g] |=> (tout[g] == $past(tout[g])) || irq_cmp[g]);
            a_r4_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
                (!run_eff[g] && !preset[g] && !pend[g]) |=> cnt[g] == $past(cnt[g]));
            a_r6_zero_after_unf: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_unf[g] && !$past(preset[g])) |-> (cnt[g] == '0 && pend[g]));
        end
    endgenerate

    a_r9_hi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode16) |-> (!irq_cmp[1] && !irq_unf[1]));
endmodule

// File: rtl/reload_cmp_timer.sv
// Top level: two 8-bit reload-compare down counters, chainable into one
// 16-bit counter, clocked by falling edges of an asynchronous timer clock.
module reload_cmp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tclk,
    input  logic         mode16,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic [1:0]   irq_cmp,
    output logic [1:0]   irq_unf,
    output logic [1:0]   tout
);
    logic              fall, rise;
    logic [1:0]        run_eff, preset;
    logic [1:0][W-1:0] rld, cmp, cnt;

    tclk_edge u_edge (
        .clk (clk), .rst_n (rst_n), .tclk (tclk), .fall (fall), .rise (rise)
    );

    timer_regs #(.W(W)) u_regs (
        .clk (clk), .rst_n (rst_n), .mode16 (mode16), .wr_en (wr_en),
        .addr (addr), .wdata (wdata), .cnt (cnt), .rdata (rdata),
        .run_eff (run_eff), .preset (preset), .rld (rld), .cmp (cmp)
    );

    timer_core #(.W(W)) u_core (
        .clk (clk), .rst_n (rst_n), .mode16 (mode16), .fall (fall), .rise (rise),
        .run_eff (run_eff), .preset (preset), .rld (rld), .cmp (cmp),
        .cnt (cnt), .irq_cmp (irq_cmp), .irq_unf (irq_unf), .tout (tout)
    );
endmodule

// File: tb/reload_cmp_timer_tb.sv
module reload_cmp_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tclk = 1'b0;
    logic       mode16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] irq_cmp, irq_unf, tout;

    int total = 0, bad = 0;
    int n_cmp0 = 0, n_cmp1 = 0, n_unf0 = 0, n_unf1 = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_cmp_timer u_dut (
        .clk (clk), .rst_n (rst_n), .tclk (tclk), .mode16 (mode16),
        .wr_en (wr_en), .addr (addr), .wdata (wdata), .rdata (rdata),
        .irq_cmp (irq_cmp), .irq_unf (irq_unf), .tout (tout)
    );

    // Count event pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_cmp[0]) n_cmp0++;
            if (irq_cmp[1]) n_cmp1++;
            if (irq_unf[0]) n_unf0++;
            if (irq_unf[1]) n_unf1++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic rise_half();
        tclk = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic fall_half();
        tclk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic tick();
        rise_half();
        fall_half();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset register", v, 0);
        end
        check("R1 reset tout", tout, 0);
        check("R1 reset pulses", {irq_cmp, irq_unf}, 0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(3'b010, 8'h5A); rd(3'b010, v); check("R2 compare0 rw", v, 8'h5A);
        wr(3'b101, 8'hC3); rd(3'b101, v); check("R2 reload1 rw", v, 8'hC3);
    endtask

    task automatic t_basic8();
        logic [7:0] v;
        wr(3'b001, 8'h03); wr(3'b010, 8'h01);
        wr(3'b000, 8'h02);
        rd(3'b011, v); check("R7 preset loads reload", v, 3);
        wr(3'b000, 8'h01);
        rd(3'b000, v); check("R4 run reads back", v, 1);
        tick(); rd(3'b011, v); check("R3 first decrement", v, 2);
        tick(); rd(3'b011, v); check("R5 count at match", v, 1);
        check("R5 compare pulse", n_cmp0, 1);
        check("R5 tout toggled", tout[0], 1);
        tick(); rd(3'b011, v); check("R3 reach zero", v, 0);
        rise_half(); fall_half();
        rd(3'b011, v); check("R6 zero held at underflow edge", v, 0);
        check("R6 underflow pulse", n_unf0, 1);
        check("R5 no extra compare", n_cmp0, 1);
        rise_half();
        rd(3'b011, v); check("R6 reload on rising edge", v, 3);
        fall_half();
        rd(3'b011, v); check("R6 continue from reload", v, 2);
    endtask

    task automatic t_stop();
        logic [7:0] v;
        wr(3'b000, 8'h00);
        tick(); tick(); tick();
        rd(3'b011, v); check("R4 frozen count", v, 2);
        check("R4 frozen tout", tout[0], 1);
        check("R4 no events when stopped", n_cmp0 + n_unf0, 2);
        wr(3'b000, 8'h01);
        tick(); rd(3'b011, v); check("R4 resume from held", v, 1);
        check("R5 second match toggles back", tout[0], 0);
        wr(3'b000, 8'h00);
    endtask

    task automatic t_indep();
        logic [7:0] v;
        wr(3'b101, 8'h05); wr(3'b100, 8'h03);
        tick();
        rd(3'b111, v); check("R8 timer1 counts alone", v, 4);
        rd(3'b011, v); check("R8 timer0 untouched", v, 1);
        wr(3'b100, 8'h00);
    endtask

    task automatic t_chain16();
        logic [7:0] v, h;
        mode16 = 1'b1;
        wr(3'b001, 8'h00); wr(3'b101, 8'h01);
        wr(3'b010, 8'hFE); wr(3'b110, 8'h00);
        wr(3'b000, 8'h02); wr(3'b100, 8'h02);
        wr(3'b100, 8'h01);
        rd(3'b100, v); check("R10 high run write ignored", v, 0);
        tick();
        rd(3'b111, h); check("R9 high half idle while low stopped", h, 1);
        wr(3'b000, 8'h01);
        tick();
        rd(3'b011, v); rd(3'b111, h);
        check("R9 borrow into high", {h, v}, 16'h00FF);
        tick();
        rd(3'b011, v); check("R2 16-bit compare value", v, 8'hFE);
        check("R9 16-bit match on index0", n_cmp0, 3);
        check("R5 16-bit tout toggle", tout[0], 1);
        for (int k = 0; k < 254; k++) tick();
        rd(3'b011, v); rd(3'b111, h);
        check("R9 reach 0000", {h, v}, 0);
        rise_half(); fall_half();
        check("R9 16-bit underflow", n_unf0, 2);
        rise_half();
        rd(3'b011, v); rd(3'b111, h);
        check("R9 both halves reloaded", {h, v}, 16'h0100);
        check("R9 index1 silent", n_cmp1 + n_unf1, 0);
        check("R9 tout1 held", tout[1], 0);
        fall_half();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_basic8();
        t_stop();
        t_indep();
        t_chain16();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule